// File: doc/BRIEF.md
# External Bus Transfer Sequencer

This block turns one internal access (byte, word, longword or 16-byte line; read or write; burst allowed or not) into a series of external bus beats. Each beat fits the data port width chosen by a configuration input, which may be 8, 16 or 32 bits. A misaligned or oversized access is cut into naturally aligned pieces. Every beat opens with a one-cycle address strobe and carries a direction bit and a 2-bit size code. The beat stays open until the target acknowledges it.

The requester sees a valid/ready handshake and a one-cycle done pulse. On the bus side, the block provides the values together with an output-enable for each of strobe, direction and size. The pad ring uses these enables to float the lines between transfers. Byte-lane steering, chip selects, wait states and arbitration are handled by other blocks.

Top module: `bus_xfer_seq`

## Requirements
- R1: `req_ready_o` is high only while idle. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high, and the first strobe follows in the next cycle. A request raised while busy is ignored.
- R2: Each beat moves the largest power-of-two byte count that meets three limits: it is no more than the port width, no more than the bytes still to move, and the beat address is a multiple of it. `port_sel_i` selects the port width: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = treated as 32 bit.
- R3: The first beat uses the request address. Each later beat address is the previous one plus the bytes moved in the previous beat. The address stays fixed throughout a beat.
- R4: Size code values are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes, 11 = 16 bytes. Operand size `req_size_i` uses the same encoding. A beat that falls under neither R5 nor R6 shows the code of its own byte count.
- R5: For an access aligned to its own size and larger than the port, with `req_burst_i` = 1, every beat shows the code of the whole operand.
- R6: For the same kind of access with `req_burst_i` = 0, the first beat shows the whole-operand code and each later beat shows the port-width code.
- R7: The strobe is high for exactly one cycle, the first cycle of each beat. A beat ends only when `ack_i` is high in a cycle after its strobe cycle. An acknowledge during the strobe cycle is ignored.
- R8: `bus_rw_o` is 1 for a read and 0 for a write, and it does not change during a transfer.
- R9: All three output-enables are high from the first strobe through the cycle of the final acknowledge, and low while idle.
- R10: `done_o` is high for exactly the one cycle after the final acknowledge. `req_ready_o` is high in that same cycle.
- R11: Reset, including a reset in the middle of a transfer, leaves the block idle: ready high, enables low, done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel_i | input | 2 | Port width select, sampled with a request |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_addr_i | input | AW | Request byte address |
| req_size_i | input | 2 | Operand size code |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_burst_i | input | 1 | 1 = bursting allowed |
| ack_i | input | 1 | Beat acknowledge |
| bus_addr_o | output | AW | Current beat address |
| bus_strobe_o | output | 1 | Address strobe, one cycle per beat |
| bus_rw_o | output | 1 | Direction value |
| bus_size_o | output | 2 | Beat size code value |
| strobe_oe_o | output | 1 | Enable for the strobe line |
| rw_oe_o | output | 1 | Enable for the direction line |
| size_oe_o | output | 2 | Enable for the size lines (both bits equal) |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The bench runs every combination of port width, operand size, byte offsets 0 to 7, direction and burst flag, and compares every beat against a model. The model takes the smallest of the port width, the alignment of the address and the largest power of two in the remaining byte count. Offset 0 against the wider operands separates the burst and inhibited size codes. The odd offsets exercise the splitting into byte, word and byte pieces. Acknowledge delays vary from beat to beat. Separate runs check that a request or an acknowledge arriving during a strobe cycle is ignored, and that a reset in the middle of a transfer returns the block to idle.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int LINE_BYTES  = 16;
  localparam int MAX_BEAT_LG = 2;
  localparam int REMW        = $clog2(LINE_BYTES) + 1;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_LINE = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  function automatic logic [1:0] lg_to_code(input logic [1:0] lg);
    case (lg)
      2'd0:    lg_to_code = SZ_BYTE;
      2'd1:    lg_to_code = SZ_WORD;
      2'd2:    lg_to_code = SZ_LONG;
      default: lg_to_code = SZ_LINE;
    endcase
  endfunction

  function automatic logic [REMW-1:0] code_to_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: code_to_bytes = REMW'(1);
      SZ_WORD: code_to_bytes = REMW'(2);
      SZ_LONG: code_to_bytes = REMW'(4);
      default: code_to_bytes = REMW'(LINE_BYTES);
    endcase
  endfunction
endpackage

// File: rtl/bxs_beat_calc.sv
module bxs_beat_calc #(
  parameter int LG_MAX = 2,
  parameter int RW     = 5
) (
  input  logic [LG_MAX-1:0] addr_lo,
  input  logic [RW-1:0]     rem,
  input  logic [1:0]        port_lg,
  output logic [1:0]        beat_lg
);
  // Largest power of two allowed by port, remaining bytes and alignment.
  always_comb begin
    beat_lg = 2'd0;
    for (int k = 1; k <= LG_MAX; k++) begin
      if ((k <= int'(port_lg)) &&
          (int'(rem) >= (1 << k)) &&
          ((int'(addr_lo) & ((1 << k) - 1)) == 0)) begin
        beat_lg = 2'(k);
      end
    end
  end
endmodule

// File: rtl/bxs_code_sel.sv
module bxs_code_sel
  import bxs_pkg::*;
(
  input  logic [1:0] beat_lg,
  input  logic [1:0] port_lg,
  input  logic [1:0] total_code,
  input  logic       big_aligned,
  input  logic       burst,
  input  logic       first_beat,
  output logic [1:0] code
);
  always_comb begin
    if (big_aligned) begin
      code = (burst || first_beat) ? total_code : lg_to_code(port_lg);
    end else begin
      code = lg_to_code(beat_lg);
    end
  end
endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq
  import bxs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    port_sel_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_read_i,
  input  logic          req_burst_i,
  input  logic          ack_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_strobe_o,
  output logic          bus_rw_o,
  output logic [1:0]    bus_size_o,
  output logic          strobe_oe_o,
  output logic          rw_oe_o,
  output logic [1:0]    size_oe_o,
  output logic          done_o
);
  localparam int ALW = MAX_BEAT_LG;

  // reset synchronizer: asserts at once, releases on clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_e      state_q, state_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [REMW-1:0] rem_q, rem_d;
  logic            first_q, first_d;
  logic [1:0]      port_lg_q, port_lg_d;
  logic [1:0]      tcode_q, tcode_d;
  logic            read_q, read_d;
  logic            burst_q, burst_d;
  logic            big_q, big_d;
  logic            done_q, done_d;
  logic            load, step, last_beat, xfer_en;

  logic [1:0]      beat_lg;
  logic [REMW-1:0] beat_bytes;
  logic [REMW-1:0] req_bytes;
  logic [1:0]      req_port_lg;
  logic [REMW-1:0] req_port_bytes;
  logic [1:0]      beat_code;

  bxs_beat_calc #(.LG_MAX(ALW), .RW(REMW)) u_beat (
    .addr_lo (addr_q[ALW-1:0]),
    .rem     (rem_q),
    .port_lg (port_lg_q),
    .beat_lg (beat_lg)
  );

  bxs_code_sel u_code (
    .beat_lg     (beat_lg),
    .port_lg     (port_lg_q),
    .total_code  (tcode_q),
    .big_aligned (big_q),
    .burst       (burst_q),
    .first_beat  (first_q),
    .code        (beat_code)
  );

  assign beat_bytes = REMW'(1) << beat_lg;
  assign last_beat  = (rem_q == beat_bytes);

  // request decode
  always_comb begin
    req_bytes      = code_to_bytes(req_size_i);
    req_port_lg    = (port_sel_i == 2'd3) ? 2'd2 : port_sel_i;
    req_port_bytes = REMW'(1) << req_port_lg;
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d = ST_ADDR;
        load    = 1'b1;
      end
      ST_ADDR: state_d = ST_WAIT;
      ST_WAIT: if (ack_i) begin
        step    = 1'b1;
        state_d = last_beat ? ST_IDLE : ST_ADDR;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    xfer_en   = load | step;
    done_d    = step & last_beat;
    addr_d    = addr_q;
    rem_d     = rem_q;
    first_d   = first_q;
    port_lg_d = port_lg_q;
    tcode_d   = tcode_q;
    read_d    = read_q;
    burst_d   = burst_q;
    big_d     = big_q;
    if (load) begin
      addr_d    = req_addr_i;
      rem_d     = req_bytes;
      first_d   = 1'b1;
      port_lg_d = req_port_lg;
      tcode_d   = req_size_i;
      read_d    = req_read_i;
      burst_d   = req_burst_i;
      big_d     = (req_bytes > req_port_bytes) &&
                  ((REMW'(req_addr_i[REMW-2:0]) & (req_bytes - REMW'(1))) == '0);
    end else if (step) begin
      addr_d  = addr_q + AW'(beat_bytes);
      rem_d   = rem_q - beat_bytes;
      first_d = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q    <= '0;
      rem_q     <= '0;
      first_q   <= 1'b0;
      port_lg_q <= 2'd0;
      tcode_q   <= SZ_LONG;
      read_q    <= 1'b0;
      burst_q   <= 1'b0;
      big_q     <= 1'b0;
    end else if (xfer_en) begin
      addr_q    <= addr_d;
      rem_q     <= rem_d;
      first_q   <= first_d;
      port_lg_q <= port_lg_d;
      tcode_q   <= tcode_d;
      read_q    <= read_d;
      burst_q   <= burst_d;
      big_q     <= big_d;
    end
  end

  // outputs
  logic busy;
  assign busy         = (state_q != ST_IDLE);
  assign req_ready_o  = (state_q == ST_IDLE);
  assign bus_strobe_o = (state_q == ST_ADDR);
  assign bus_addr_o   = addr_q;
  assign bus_rw_o     = busy & read_q;
  assign bus_size_o   = busy ? beat_code : SZ_LONG;
  assign strobe_oe_o  = busy;
  assign rw_oe_o      = busy;
  assign size_oe_o    = {2{busy}};
  assign done_o       = done_q;
endmodule

// File: rtl/bxs_checker.sv
module bxs_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_strobe_o,
  input logic          bus_rw_o,
  input logic [1:0]    bus_size_o,
  input logic          strobe_oe_o,
  input logic          rw_oe_o,
  input logic          done_o
);
  p_accept_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> bus_strobe_o);

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !strobe_oe_o);

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe_o |=> !bus_strobe_o);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe_o |=> $stable(bus_addr_o));

  p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe_o |=> $stable(bus_size_o));

  p_rw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_oe_o && !bus_strobe_o) |-> $stable(bus_rw_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!strobe_oe_o && req_ready_o));
endmodule

bind bus_xfer_seq bxs_checker #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .bus_addr_o   (bus_addr_o),
  .bus_strobe_o (bus_strobe_o),
  .bus_rw_o     (bus_rw_o),
  .bus_size_o   (bus_size_o),
  .strobe_oe_o  (strobe_oe_o),
  .rw_oe_o      (rw_oe_o),
  .done_o       (done_o)
);

// File: tb/bus_xfer_seq_tb_top.sv
module bus_xfer_seq_tb_top;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic [1:0]    port_sel_i;
  logic          req_valid_i;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i;
  logic [1:0]    req_size_i;
  logic          req_read_i;
  logic          req_burst_i;
  logic          ack_i;
  logic [AW-1:0] bus_addr_o;
  logic          bus_strobe_o;
  logic          bus_rw_o;
  logic [1:0]    bus_size_o;
  logic          strobe_oe_o;
  logic          rw_oe_o;
  logic [1:0]    size_oe_o;
  logic          done_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  bus_xfer_seq #(.AW(AW)) dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int code_bytes(input logic [1:0] c);
    case (c)
      2'b01: return 1;
      2'b10: return 2;
      2'b00: return 4;
      default: return 16;
    endcase
  endfunction

  function automatic logic [1:0] bytes_code(input int b);
    if (b == 1) return 2'b01;
    if (b == 2) return 2'b10;
    if (b == 4) return 2'b00;
    return 2'b11;
  endfunction

  function automatic int model_beat(input int port_b, input int rem, input int addr);
    int lowbit, fp, m;
    lowbit = (addr == 0) ? 64 : (addr & -addr);
    fp = 1;
    while (fp * 2 <= rem) fp = fp * 2;
    m = port_b;
    if (lowbit < m) m = lowbit;
    if (fp < m) m = fp;
    return m;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_xfer(input int psel, input logic [1:0] sz, input int off,
                          input bit rd, input bit bst, input bit poke);
    int port_b, tot, rem, addr, beat, b, d;
    bit big, first;
    logic [1:0] ecode;
    port_b = 1 << ((psel == 3) ? 2 : psel);
    tot    = code_bytes(sz);
    addr   = 32'h1000_0000 + off;
    rem    = tot;
    big    = (tot > port_b) && ((addr % tot) == 0);
    first  = 1;
    beat   = 0;
    check(req_ready_o == 1'b1, "R1 ready before request", req_ready_o, 1);
    port_sel_i  = 2'(psel);
    req_addr_i  = AW'(addr);
    req_size_i  = sz;
    req_read_i  = rd;
    req_burst_i = bst;
    req_valid_i = 1'b1;
    tick();
    req_valid_i = 1'b0;
    port_sel_i  = 2'd0;
    while (rem > 0) begin
      b = model_beat(port_b, rem, addr);
      if (big) ecode = (bst || first) ? sz : bytes_code(port_b);
      else     ecode = bytes_code(b);
      check(bus_strobe_o == 1'b1, "R7 strobe at beat start", bus_strobe_o, 1);
      check(bus_addr_o == AW'(addr), "R2 R3 beat address", bus_addr_o, addr);
      if (big && bst)
        check(bus_size_o == ecode, "R5 burst size code", bus_size_o, ecode);
      else if (big)
        check(bus_size_o == ecode, "R6 inhibited size code", bus_size_o, ecode);
      else
        check(bus_size_o == ecode, "R2 R4 beat size code", bus_size_o, ecode);
      check(bus_rw_o == rd, "R8 direction", bus_rw_o, rd);
      check(strobe_oe_o && rw_oe_o && (size_oe_o == 2'b11), "R9 enables on",
            {strobe_oe_o, rw_oe_o, size_oe_o}, 4'hF);
      check(req_ready_o == 1'b0, "R1 busy not ready", req_ready_o, 0);
      if (poke && beat == 0) begin
        ack_i       = 1'b1;
        req_valid_i = 1'b1;
        req_addr_i  = 32'h2000_0000;
        req_size_i  = 2'b01;
        tick();
        ack_i       = 1'b0;
        req_valid_i = 1'b0;
        tick();
        check(bus_strobe_o == 1'b0 && strobe_oe_o, "R7 ack in strobe cycle ignored",
              {bus_strobe_o, strobe_oe_o}, 1);
        check(bus_addr_o == AW'(addr), "R1 request while busy ignored", bus_addr_o, addr);
      end else begin
        tick();
      end
      check(bus_strobe_o == 1'b0, "R7 strobe one cycle", bus_strobe_o, 0);
      d = (beat + off) % 3;
      for (int i = 0; i < d; i++) begin
        tick();
        check(bus_strobe_o == 1'b0 && bus_addr_o == AW'(addr), "R7 waits for ack",
              bus_strobe_o, 0);
      end
      ack_i = 1'b1;
      tick();
      ack_i = 1'b0;
      addr  = addr + b;
      rem   = rem - b;
      first = 0;
      beat++;
    end
    check(done_o == 1'b1, "R10 done after final ack", done_o, 1);
    check(req_ready_o == 1'b1, "R10 ready with done", req_ready_o, 1);
    check(!strobe_oe_o && !rw_oe_o && (size_oe_o == 2'b00), "R9 enables off",
          {strobe_oe_o, rw_oe_o, size_oe_o}, 0);
    tick();
    check(done_o == 1'b0, "R10 done single cycle", done_o, 0);
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        tick();
        check(bus_strobe_o == 1'b0 && !strobe_oe_o, "R1 no beat from ignored request",
              bus_strobe_o, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    port_sel_i  = 2'd0;
    req_valid_i = 1'b0;
    req_addr_i  = '0;
    req_size_i  = 2'b00;
    req_read_i  = 1'b0;
    req_burst_i = 1'b0;
    ack_i       = 1'b0;
    repeat (3) tick();
    check(req_ready_o && !strobe_oe_o && !done_o, "R11 reset state",
          {req_ready_o, strobe_oe_o, done_o}, 3'b100);
    rst_n = 1'b1;
    repeat (3) tick();
    check(req_ready_o && !strobe_oe_o && !done_o, "R11 idle after release",
          {req_ready_o, strobe_oe_o, done_o}, 3'b100);

    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 8; o++)
          for (int r = 0; r < 2; r++)
            for (int bb = 0; bb < 2; bb++)
              run_xfer(p, 2'(s), o, r[0], bb[0], 1'b0);

    run_xfer(0, 2'b11, 0, 1'b1, 1'b1, 1'b1);
    run_xfer(2, 2'b00, 1, 1'b0, 1'b0, 1'b1);

    // reset in the middle of a line transfer
    port_sel_i  = 2'd0;
    req_addr_i  = 32'h3000_0000;
    req_size_i  = 2'b11;
    req_read_i  = 1'b1;
    req_burst_i = 1'b1;
    req_valid_i = 1'b1;
    tick();
    req_valid_i = 1'b0;
    tick();
    check(strobe_oe_o == 1'b1, "R9 busy before reset", strobe_oe_o, 1);
    rst_n = 1'b0;
    tick();
    check(req_ready_o && !strobe_oe_o && !rw_oe_o && !done_o, "R11 reset mid transfer",
          {req_ready_o, strobe_oe_o, rw_oe_o, done_o}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) tick();
    run_xfer(1, 2'b00, 2, 1'b1, 1'b0, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule